// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Enables

This block holds six alarm registers, one each for seconds, minutes, hours, weekday, day of month and month. It compares them against the live calendar counts that a separate counter block supplies in BCD. Each alarm register carries its own enable bit, and only the enabled fields take part in the compare. Software can therefore ask for a full date-and-time alarm, or for a repeating one such as "minute 15 of every hour", by enabling just the minutes field.

When every enabled field equals its live count, the block sets a sticky alarm flag. It sets the flag once, on the cycle after the match begins, and not again while that match lasts. The interrupt line follows the flag, gated by an interrupt-enable bit. Software reaches both the alarm registers and the control bits through a byte-wide register port with write strobe, address, write data and combinational read data. Software acknowledges the alarm by writing 0 to the flag bit.

Top module: `cal_alarm_match`

## Requirements
- R1: After synchronous active-low reset, every alarm register, the flag and the interrupt enable read 0, and `alarm_irq` is low.
- R2: The alarm registers sit at addresses 8 to 13, in the order seconds, minutes, hours, weekday, day, month. A write stores the full byte, and a read at the same address returns it.
- R3: Bit 7 of an alarm register enables that field. Bits 6:0 hold the BCD value, which is compared with live field i at `live_bcd[7*i+6:7*i]`, where i = 0 is seconds and i = 5 is month.
- R4: The match condition is the AND over the enabled fields only. A field whose enable is clear never blocks a match, whatever its value.
- R5: While no field is enabled, the flag is never set.
- R6: The flag is set at the clock edge after the edge at which the match condition turns from false to true. Once set, it holds. It is not set again while the same match continues, even if it was cleared in between.
- R7: The control register sits at address 14. Bit 0 is the alarm flag, bit 3 is the interrupt enable, and all other bits read 0. Writing 0 to bit 0 clears the flag. Writing 1 to bit 0 leaves the flag unchanged. Bit 3 stores the written value.
- R8: `alarm_irq` is high exactly when the flag and the interrupt enable are both set.
- R9: If a clearing write to the control register falls in the same cycle as a new match edge, the flag ends up set.
- R10: Writes to any address other than 8 to 14 change no register, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| live_bcd | input | 42 | Live BCD counts, 7 bits per field, seconds in the lowest slice |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The hardest case to reach is a match that persists after software has cleared the flag. To reach it, the stimulus holds the live counts steady across the clearing write, then breaks the match and restores it. The second hard case is the collision in R9. To reach it, the bench first sets the flag, then breaks the match. It then issues the clearing write in the same cycle that the live counts return to the alarm value. A reference model inside the bench predicts the flag, the interrupt line and the read data after every edge.

// File: rtl/cal_alarm_pkg.sv
// Package: shared constants and types for the calendar alarm comparator.
// Assumes one byte-wide register port and BCD live counts supplied by a counter block.
package cal_alarm_pkg;

    // Number of compared calendar fields and the width of one BCD field.
    localparam int FIELD_N  = 6;
    localparam int FIELD_W  = 7;
    localparam int REG_W    = FIELD_W + 1;
    localparam int ENA_BIT  = FIELD_W;

    // Register port geometry: the alarm block follows the year counter slot.
    localparam int ADDR_W    = 4;
    localparam int ALM_BASE  = 8;
    localparam int CTRL_ADDR = ALM_BASE + FIELD_N;

    // Control register bit positions.
    localparam int FLAG_BIT = 0;
    localparam int AIE_BIT  = 3;

    // Field index order, which also sets the register order and the live slice order.
    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_DAY  = 3'd4,
        FLD_MON  = 3'd5
    } cal_field_e;

endpackage

// File: rtl/alarm_regfile.sv
// Module: alarm_regfile
// Holds the per-field alarm registers and the interrupt-enable bit, decodes writes,
// and builds the read data. The flag itself lives in alarm_flag_ctl and is fed back
// here only for readback. Assumes a single-cycle write strobe and combinational reads.
module alarm_regfile #(
    parameter int FIELDS    = 6,
    parameter int BCD_W     = 7,
    parameter int AW        = 4,
    parameter int BASE      = 8,
    parameter int CTRL      = 14,
    parameter int FLAG_POS  = 0,
    parameter int AIE_POS   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [AW-1:0]             addr,
    input  logic [BCD_W:0]            wdata,
    input  logic                      flag,
    output logic [BCD_W:0]            rdata,
    output logic [FIELDS*BCD_W-1:0]   alm_val,
    output logic [FIELDS-1:0]         alm_en,
    output logic                      aie,
    output logic                      clr_req
);

    localparam int RW = BCD_W + 1;
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL);

    logic [RW-1:0] regs [FIELDS];
    logic          ctrl_sel;

    // Control register select, shared by the enable bit and the flag clear request.
    assign ctrl_sel = wr && (addr == CTRL_A);

    // A write of 0 to the flag bit asks the flag controller to clear the flag.
    assign clr_req = ctrl_sel && !wdata[FLAG_POS];

    genvar g;
    generate
        for (g = 0; g < FIELDS; g++) begin : g_field
            localparam logic [AW-1:0] FA = AW'(BASE + g);
            logic sel;

            // Per-field write decode.
            assign sel = wr && (addr == FA);

            // Per-field alarm register storage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (sel) begin
                    regs[g] <= wdata;
                end
            end

            // Split the stored byte into compare value and enable.
            assign alm_val[g*BCD_W +: BCD_W] = regs[g][BCD_W-1:0];
            assign alm_en[g]                 = regs[g][BCD_W];
        end
    endgenerate

    // Interrupt-enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aie <= 1'b0;
        end else if (ctrl_sel) begin
            aie <= wdata[AIE_POS];
        end
    end

    // Read data multiplexer: alarm registers, the control register, or zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < FIELDS; i++) begin
            if (addr == AW'(BASE + i)) begin
                rdata = regs[i];
            end
        end
        if (addr == CTRL_A) begin
            rdata[FLAG_POS] = flag;
            rdata[AIE_POS]  = aie;
        end
    end

endmodule

// File: rtl/alarm_field_cmp.sv
// Module: alarm_field_cmp
// Compares every enabled alarm field with its live BCD count and reduces the result
// to one match bit. A disabled field always counts as a hit. With no field enabled,
// the match bit stays low. Purely combinational.
module alarm_field_cmp #(
    parameter int FIELDS = 6,
    parameter int BCD_W  = 7
) (
    input  logic [FIELDS*BCD_W-1:0] alm_val,
    input  logic [FIELDS-1:0]       alm_en,
    input  logic [FIELDS*BCD_W-1:0] live,
    output logic                    match
);

    logic [FIELDS-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < FIELDS; g++) begin : g_cmp
            // One field: a hit when the field is disabled or its value equals the live count.
            assign hit[g] = !alm_en[g] ||
                            (alm_val[g*BCD_W +: BCD_W] == live[g*BCD_W +: BCD_W]);
        end
    endgenerate

    // Reduce: every field must hit, and at least one field must take part.
    assign match = (&hit) && (|alm_en);

endmodule

// File: rtl/alarm_flag_ctl.sv
// Module: alarm_flag_ctl
// Registers the match bit and sets a sticky flag on its rising edge. A clear request
// drops the flag unless a new match edge arrives in the same cycle, in which case the
// set wins. Assumes match is already free of glitches, since it is sampled only at the clock edge.
module alarm_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic clr_req,
    output logic match_q,
    output logic flag
);

    logic rise;

    // Edge detect on the match condition.
    assign rise = match && !match_q;

    // Previous-cycle match, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= match;
        end
    end

    // Sticky flag: set by a match edge, cleared by software, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (rise) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cal_alarm_match.sv
// Module: cal_alarm_match (top)
// Alarm comparator with per-field enables. It ties together the register file, the
// field comparator and the flag controller, and gates the interrupt with the enable.
// Assumes live_bcd changes only at clock edges, in the domain of clk.
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int FIELDS = FIELD_N,
    parameter int BCD_W  = FIELD_W,
    parameter int AW     = ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [AW-1:0]           bus_addr,
    input  logic [BCD_W:0]          bus_wdata,
    output logic [BCD_W:0]          bus_rdata,
    input  logic [FIELDS*BCD_W-1:0] live_bcd,
    output logic                    alarm_flag,
    output logic                    alarm_irq
);

    localparam int CTRL_A = ALM_BASE + FIELDS;

    logic [FIELDS*BCD_W-1:0] alm_val;
    logic [FIELDS-1:0]       alm_en;
    logic                    aie;
    logic                    clr_req;
    logic                    match_all;
    logic                    match_prev;

    // Register storage and bus decode.
    alarm_regfile #(
        .FIELDS   (FIELDS),
        .BCD_W    (BCD_W),
        .AW       (AW),
        .BASE     (ALM_BASE),
        .CTRL     (CTRL_A),
        .FLAG_POS (FLAG_BIT),
        .AIE_POS  (AIE_BIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .flag    (alarm_flag),
        .rdata   (bus_rdata),
        .alm_val (alm_val),
        .alm_en  (alm_en),
        .aie     (aie),
        .clr_req (clr_req)
    );

    // Enabled-field comparison.
    alarm_field_cmp #(
        .FIELDS (FIELDS),
        .BCD_W  (BCD_W)
    ) u_cmp (
        .alm_val (alm_val),
        .alm_en  (alm_en),
        .live    (live_bcd),
        .match   (match_all)
    );

    // Flag sequencing.
    alarm_flag_ctl u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .match   (match_all),
        .clr_req (clr_req),
        .match_q (match_prev),
        .flag    (alarm_flag)
    );

    // Interrupt request: the flag qualified by its enable.
    assign alarm_irq = alarm_flag && aie;

endmodule

// File: rtl/cal_alarm_match_chk.sv
// Module: cal_alarm_match_chk
// Checker bound to cal_alarm_match. It observes the bus, the match path and the
// flag outputs, and checks their timing relations.
module cal_alarm_match_chk #(
    parameter int FIELDS = 6,
    parameter int AW     = 4,
    parameter int CTRL   = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              match_all,
    input logic              match_prev,
    input logic [FIELDS-1:0] alm_en,
    input logic              aie,
    input logic              alarm_flag,
    input logic              alarm_irq
);

    logic clr_wr;
    logic new_edge;

    assign clr_wr   = bus_wr && (bus_addr == AW'(CTRL)) && !bus_wdata[0];
    assign new_edge = match_all && !match_prev;

    // R6: a new match edge sets the flag one cycle later
    a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        new_edge |=> alarm_flag);

    // R6: the flag only rises after a cycle in which the match held
    a_r6_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(match_all));

    // R6: the flag holds unless software clears it
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !clr_wr) |=> alarm_flag);

    // R5: no rise without at least one enabled field
    a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(alm_en != '0));

    // R7: a clearing write without a competing edge drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !new_edge) |=> !alarm_flag);

    // R9: a clearing write that meets a new edge leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && new_edge) |=> alarm_flag);

    // R8: the interrupt needs the flag and the enable
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (alarm_flag && aie));

endmodule

bind cal_alarm_match cal_alarm_match_chk #(
    .FIELDS (FIELDS),
    .AW     (AW),
    .CTRL   (CTRL_A)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .match_all  (match_all),
    .match_prev (match_prev),
    .alm_en     (alm_en),
    .aie        (aie),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq)
);

// File: tb/cal_alarm_match_bench.sv
// Scoreboard bench: the driver applies one bus/live pattern per cycle. It steps a
// reference model at the clock edge and queues the expected outputs. A monitor pops
// and compares them 5 ns after each edge.
module cal_alarm_match_bench;

    typedef struct {
        string    tag;
        bit       flag;
        bit       irq;
        bit [7:0] rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [41:0] live_bcd = '0;
    logic [7:0]  bus_rdata;
    logic        alarm_flag;
    logic        alarm_irq;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   cycles = 0;
    bit   done = 0;

    // Reference model state.
    bit [7:0] m_reg [6];
    bit       m_flag, m_aie, m_prev;

    always #10 clk = ~clk;

    cal_alarm_match u_cal_alarm_match (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .live_bcd(live_bcd),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    function automatic [41:0] mk(input [6:0] s, mi, h, w, d, mo);
        return {mo, d, w, h, mi, s};
    endfunction

    function automatic bit model_match(input [41:0] lv);
        bit all = 1, any = 0;
        for (int i = 0; i < 6; i++) begin
            if (m_reg[i][7]) begin
                any = 1;
                if (m_reg[i][6:0] != lv[7*i +: 7]) all = 0;
            end
        end
        return all && any;
    endfunction

    function automatic [7:0] model_rd(input [3:0] a);
        if (a >= 8 && a <= 13) return m_reg[a - 8];
        if (a == 14) return {4'b0, m_aie, 2'b0, m_flag};
        return 8'h00;
    endfunction

    // Driver: one cycle of stimulus, model step at the edge, expected item queued.
    task automatic op(input bit w, input [3:0] a, input [7:0] d, input [41:0] lv,
                      input string tag);
        bit mc;
        exp_t e;
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; live_bcd = lv;
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_reg[i] = 0;
            m_flag = 0; m_aie = 0; m_prev = 0;
        end else begin
            mc = model_match(lv);
            if (mc && !m_prev) m_flag = 1;
            else if (w && a == 14 && !d[0]) m_flag = 0;
            if (w && a >= 8 && a <= 13) m_reg[a - 8] = d;
            if (w && a == 14) m_aie = d[3];
            m_prev = mc;
        end
        #1;
        e.tag = tag; e.flag = m_flag; e.irq = m_flag && m_aie; e.rd = model_rd(a);
        q.push_back(e);
    endtask

    // Monitor: compare design outputs with queued expectations away from the edge.
    always @(posedge clk) begin
        #5;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (alarm_flag !== e.flag || alarm_irq !== e.irq || bus_rdata !== e.rd) begin
                bad++;
                $display("FAIL %s: flag=%0b irq=%0b rd=%02h expected flag=%0b irq=%0b rd=%02h",
                         e.tag, alarm_flag, alarm_irq, bus_rdata, e.flag, e.irq, e.rd);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [41:0] t0, t1, t2;
        t0 = mk(7'h30, 7'h15, 7'h12, 7'h03, 7'h21, 7'h06);
        t1 = mk(7'h31, 7'h15, 7'h12, 7'h03, 7'h21, 7'h06);
        t2 = mk(7'h00, 7'h16, 7'h12, 7'h03, 7'h21, 7'h06);
        for (int i = 0; i < 3; i++) op(0, 4'd14, 8'h00, '0, "R1 during reset");
        @(negedge clk); rst_n = 1'b1;
        // R1: reset readback of every register
        for (int a = 7; a <= 15; a++) op(0, 4'(a), 8'h00, '0, "R1 reset readback");

        // R2/R3: program a full date alarm, all enabled, and read it back
        op(1, 4'd8,  8'hB0, t2, "R2 write sec");
        op(1, 4'd9,  8'h95, t2, "R2 write min");
        op(1, 4'd10, 8'h92, t2, "R2 write hour");
        op(1, 4'd11, 8'h83, t2, "R2 write wday");
        op(1, 4'd12, 8'hA1, t2, "R2 write day");
        op(1, 4'd13, 8'h86, t2, "R2 write month");
        for (int a = 8; a <= 13; a++) op(0, 4'(a), 8'h00, t2, "R2 readback");

        // R4/R6: full match sets the flag one cycle after the match edge
        op(0, 4'd14, 8'h00, t0, "R6 match edge");
        op(0, 4'd14, 8'h00, t0, "R6 flag set");
        op(0, 4'd14, 8'h00, t1, "R4 one field off, flag holds");

        // R7/R8: enable interrupt while keeping the flag (bit0=1), then clear
        op(1, 4'd14, 8'h09, t1, "R8 aie set, flag kept");
        op(0, 4'd14, 8'h00, t1, "R8 irq high");
        op(1, 4'd14, 8'h08, t1, "R7 clear flag");
        op(1, 4'd14, 8'h09, t1, "R7 write 1 does not set");

        // R6: match persisting after clear does not re-set; drop and return re-sets
        op(0, 4'd14, 8'h00, t0, "R6 new edge");
        op(1, 4'd14, 8'h08, t0, "R6 clear during match");
        op(0, 4'd14, 8'h00, t0, "R6 no re-set during match");
        op(0, 4'd14, 8'h00, t0, "R6 still no re-set");

        // R9: clear write collides with a new match edge
        op(0, 4'd14, 8'h00, t1, "R9 break match");
        op(0, 4'd14, 8'h00, t0, "R9 edge");
        op(0, 4'd14, 8'h00, t1, "R9 flag set, break");
        op(1, 4'd14, 8'h08, t0, "R9 clear with edge");
        op(0, 4'd14, 8'h00, t0, "R9 set wins");

        // R4: only minutes enabled at 15, other fields disabled with mismatching values
        op(1, 4'd14, 8'h08, t2, "R4 clear");
        for (int a = 8; a <= 13; a++)
            op(1, 4'(a), (a == 9) ? 8'h95 : 8'h44, t2, "R4 minutes only");
        op(0, 4'd14, 8'h00, mk(7'h05, 7'h15, 7'h01, 7'h02, 7'h09, 7'h11), "R4 partial edge");
        op(0, 4'd14, 8'h00, mk(7'h06, 7'h15, 7'h01, 7'h02, 7'h09, 7'h11), "R4 partial set");
        op(0, 4'd9, 8'h00, mk(7'h07, 7'h15, 7'h23, 7'h02, 7'h09, 7'h11), "R3 readback");

        // R5: nothing enabled, live equals stored values
        op(1, 4'd14, 8'h08, t2, "R5 clear");
        for (int a = 8; a <= 13; a++) op(1, 4'(a), 8'h15, t2, "R5 disable all");
        op(0, 4'd14, 8'h00, mk(7'h15, 7'h15, 7'h15, 7'h15, 7'h15, 7'h15), "R5 equal");
        op(0, 4'd14, 8'h00, mk(7'h15, 7'h15, 7'h15, 7'h15, 7'h15, 7'h15), "R5 no flag");

        // R10: writes outside the map are ignored
        op(1, 4'd7, 8'hFF, t2, "R10 write 7");
        op(1, 4'd15, 8'hFF, t2, "R10 write 15");
        op(0, 4'd7, 8'h00, t2, "R10 read 7");
        op(0, 4'd15, 8'h00, t2, "R10 read 15");
        for (int a = 8; a <= 14; a++) op(0, 4'(a), 8'h00, t2, "R10 map unchanged");

        // R1: reset again clears state
        @(negedge clk); rst_n = 1'b0;
        op(0, 4'd14, 8'h00, t2, "R1 reset");
        @(negedge clk); rst_n = 1'b1;
        op(0, 4'd8, 8'h00, t2, "R1 alarm cleared by reset");

        repeat (2) @(posedge clk);
        #8;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule